// File: doc/BRIEF.md
# Serial Unsigned Integer to Single-Precision Float Converter

This block takes a 32-bit unsigned integer and returns its IEEE-754 single-precision encoding. It finds the leading one by moving the operand left one place per clock while an exponent counter steps down from its starting value. When the leading one leaves the top of the working register, the counter holds the biased exponent and the working register holds the fraction bits. A zero operand skips the loop and yields the all-zero encoding.

A client raises `start` for one cycle with `operand` while `busy` is low. `busy` stays high during the conversion. `done` then pulses for one cycle, and `result` carries the packed value until the next conversion finishes. The fraction is truncated, and the conversion time depends on where the leading one sits.

Top module: `uint_to_float_seq`

## Requirements
- R1: An operand of 0 bypasses shifting and produces result 0x00000000, with `done` high after the first rising edge following the edge that accepts `start`.
- R2: Bit 31 of `result` (sign) is always 0.
- R3: For a nonzero operand whose highest set bit is at position p, result bits 30:23 hold 127+p, and bits 22:0 hold operand bits p-1 down to p-23, with zeros below bit 0 of the operand.
- R4: Any operand with bit 31 set gives an exponent field of 158.
- R5: An operand of 1 gives result 0x3F800000.
- R6: Operand bits below position p-23 are discarded without rounding, so 0xFFFFFFFF gives 0x4F7FFFFF and 0x01FFFFFF gives 0x4BFFFFFF.
- R7: A `start` is accepted on a rising edge where `busy` is low. `busy` is high from the next edge onward, and for a nonzero operand `done` goes high after edge 33-p counted from the accepting edge, with `busy` low in that same cycle.
- R8: A `start` that arrives while `busy` is high is ignored. The running conversion's result and timing are unchanged, and no second conversion follows.
- R9: `done` is high for exactly one cycle per conversion, and `result` changes only in a cycle where `done` is high.
- R10: While reset is asserted and after it is released, `busy` and `done` are 0 and `result` is 0x00000000 until the first conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Conversion request, sampled while idle |
| operand | input | 32 | Unsigned integer to convert |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed single-precision value |

## Verification
The reference model predicts `busy`, `done` and `result` for every cycle, so a fault in the shift counter or state register appears at the ports within the conversion where it occurs. A stop that comes one shift early or late shows up twice: `done` appears one cycle off, and the exponent field is off by one, with the fraction shifted by one place. A wrong zero flag or packing select corrupts `result` in the same cycle as `done`. Starts injected while busy expose an accept rule that leaks, because the conversion would restart and `done` would come late.

// File: rtl/uif_pkg.sv
package uif_pkg;
  localparam int unsigned INT_W   = 32;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned FRAC_W  = 23;
  localparam int unsigned BIAS    = 127;
  localparam int unsigned EXP_INIT = BIAS + INT_W;
  localparam int unsigned FLT_W   = 1 + EXP_W + FRAC_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_PACK  = 2'd2
  } uif_state_e;
endpackage

// File: rtl/uif_ctrl.sv
module uif_ctrl
  import uif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_zero,
  input  logic lead_out,
  output logic load_en,
  output logic shift_en,
  output logic pack_en,
  output logic busy
);
  uif_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    shift_en = 1'b0;
    pack_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          state_d = op_zero ? ST_PACK : ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        shift_en = 1'b1;
        if (lead_out) state_d = ST_PACK;
      end
      ST_PACK: begin
        pack_en = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/uif_norm.sv
module uif_norm
  import uif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              shift_en,
  input  logic [INT_W-1:0]  operand,
  output logic [INT_W-1:0]  work,
  output logic [EXP_W-1:0]  exp_cnt,
  output logic              zero_q,
  output logic              lead_out
);
  logic [INT_W-1:0] work_d;
  logic [EXP_W-1:0] exp_d;
  logic             zero_d;

  always_comb begin
    work_d = work;
    exp_d  = exp_cnt;
    zero_d = zero_q;
    if (load_en) begin
      work_d = operand;
      exp_d  = EXP_W'(EXP_INIT);
      zero_d = (operand == '0);
    end else if (shift_en) begin
      work_d = {work[INT_W-2:0], 1'b0};
      exp_d  = exp_cnt - EXP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work    <= '0;
      exp_cnt <= '0;
      zero_q  <= 1'b0;
    end else if (load_en || shift_en) begin
      work    <= work_d;
      exp_cnt <= exp_d;
      zero_q  <= zero_d;
    end
  end

  assign lead_out = work[INT_W-1];
endmodule

// File: rtl/uif_pack.sv
module uif_pack
  import uif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pack_en,
  input  logic              zero_q,
  input  logic [EXP_W-1:0]  exp_cnt,
  input  logic [INT_W-1:0]  work,
  output logic [FLT_W-1:0]  result,
  output logic              done
);
  logic [FLT_W-1:0] packed_d;

  always_comb begin
    if (zero_q) packed_d = '0;
    else        packed_d = {1'b0, exp_cnt, work[INT_W-1 -: FRAC_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= pack_en;
      if (pack_en) result <= packed_d;
    end
  end
endmodule

// File: rtl/uint_to_float_seq.sv
module uint_to_float_seq
  import uif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INT_W-1:0]  operand,
  output logic              busy,
  output logic              done,
  output logic [FLT_W-1:0]  result
);
  logic             load_en, shift_en, pack_en, lead_out, zero_q;
  logic [INT_W-1:0] work;
  logic [EXP_W-1:0] exp_cnt;

  uif_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_zero(operand == '0),
    .lead_out(lead_out), .load_en(load_en), .shift_en(shift_en),
    .pack_en(pack_en), .busy(busy)
  );

  uif_norm u_norm (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
    .operand(operand), .work(work), .exp_cnt(exp_cnt), .zero_q(zero_q),
    .lead_out(lead_out)
  );

  uif_pack u_pack (
    .clk(clk), .rst_n(rst_n), .pack_en(pack_en), .zero_q(zero_q),
    .exp_cnt(exp_cnt), .work(work), .result(result), .done(done)
  );
endmodule

// File: rtl/uif_chk.sv
module uif_chk
  import uif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [INT_W-1:0]  operand,
  input logic              busy,
  input logic              done,
  input logic [FLT_W-1:0]  result
);
  // R2
  sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result[FLT_W-1]);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R1
  zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && operand == '0) |=> busy ##1 (done && result == '0));
endmodule

bind uint_to_float_seq uif_chk u_chk (.*);

// File: tb/sim_uint_to_float_seq.sv
module sim_uint_to_float_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic        busy, done;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  uint_to_float_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .busy(busy), .done(done), .result(result)
  );

  function automatic int lead_pos(input logic [31:0] v);
    int p = -1;
    for (int i = 0; i < 32; i++) if (v[i]) p = i;
    return p;
  endfunction

  function automatic logic [31:0] ref_conv(input logic [31:0] v);
    int p;
    logic [63:0] s;
    if (v == 0) return 32'h0;
    p = lead_pos(v);
    s = {32'h0, v} << (32 - p);
    return {1'b0, 8'(127 + p), s[31:9]};
  endfunction

  function automatic int ref_lat(input logic [31:0] v);
    if (v == 0) return 1;
    return 33 - lead_pos(v);
  endfunction

  // Cycle model
  bit          m_busy, m_done;
  int          m_cnt;
  logic [31:0] m_res, m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = 0; m_pend = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_res = m_pend; end
      end else if (start) begin
        m_busy = 1; m_cnt = ref_lat(operand); m_pend = ref_conv(operand);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp_v);
    end
  endtask

  always @(negedge clk) if (live) begin
    check("R7 busy per cycle", {31'b0, busy}, {31'b0, m_busy});
    check("R9 done per cycle", {31'b0, done}, {31'b0, m_done});
    check("R3 result per cycle", result, m_res);
  end

  task automatic convert(input logic [31:0] op, input string tag, input bit inj);
    int n = 0;
    logic [31:0] hold;
    @(negedge clk);
    start = 1; operand = op;
    do begin
      @(negedge clk);
      n++;
      if (inj && n == 3) begin start = 1; operand = ~op; end
      else start = 0;
    end while (!done && n < 40);
    start = 0;
    check({tag, " result"}, result, ref_conv(op));
    check("R2 sign", {31'b0, result[31]}, 32'h0);
    check(inj ? "R8 latency with ignored start" : "R7 latency", n, ref_lat(op) + 1);
    hold = result;
    repeat (3) @(negedge clk);
    check("R9 hold", result, hold);
    check("R8 R9 no extra done", {31'b0, done | busy}, 32'h0);
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        repeat (100000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    check("R10 reset busy", {31'b0, busy}, 32'h0);
    check("R10 reset done", {31'b0, done}, 32'h0);
    check("R10 reset result", result, 32'h0);
    @(negedge clk);
    rst_n = 1;
    live = 1;
    @(negedge clk);
    check("R10 post-reset result", result, 32'h0);

    convert(32'h0000_0001, "R5", 0);
    check("R5 one", result, 32'h3F80_0000);
    convert(32'h0000_0000, "R1", 0);
    check("R1 zero", result, 32'h0);
    convert(32'h8000_0000, "R4", 0);
    check("R4 exp", {24'h0, result[30:23]}, 32'd158);
    convert(32'hFFFF_FFFF, "R6", 0);
    check("R6 all ones", result, 32'h4F7F_FFFF);
    convert(32'h01FF_FFFF, "R6", 0);
    check("R6 25 bits", result, 32'h4BFF_FFFF);
    convert(32'h00FF_FFFF, "R3", 0);
    for (int i = 0; i < 32; i++) convert(32'h1 << i, "R3 power of two", 0);
    convert(32'h0000_0005, "R8", 1);
    convert(32'h0000_0000, "R8 zero", 1);
    for (int i = 0; i < 150; i++) begin
      logic [31:0] r = $urandom;
      r = r >> ($urandom % 32);
      convert(r, "R3 random", (i % 7) == 0);
    end
    // back-to-back: start held in the done cycle
    @(negedge clk);
    start = 1; operand = 32'h0000_0300;
    @(negedge clk); start = 0;
    while (!done && wd < 40) begin @(negedge clk); wd++; end
    start = 1; operand = 32'h8000_0001;
    @(negedge clk); start = 0;
    check("R7 accept in done cycle", {31'b0, busy}, 32'h1);
    repeat (40) @(negedge clk);
    check("R4 back-to-back", result, 32'h4F00_0000);

    live = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule